// File: doc/BRIEF.md
# SDRAM Open-Row Access Sequencer

This block sits between a simple request/acknowledge bus and a single SDRAM device. It converts each read or write request into command words on chip-select, RAS, CAS and WE, with the row or the column placed on a multiplexed address bus and the bank on separate bank pins. A small table records whether each bank has a row open and which row it is. Each request then takes one of three paths. A row hit goes straight to the column command. A bank with no open row gets an activate first. A bank with a different row open gets a precharge, then an activate.

Each request carries three flags. A direction bit selects read or write. A burst flag is set on every beat of a multi-beat transfer except the last. A load-multiple flag marks a cache-line fill. Read data returns after a programmable CAS latency, and the acknowledge is raised in the cycle the word is valid. After the last read beat, a burst-terminate command is issued one cycle after the read, so the device stops streaming. Writes drive their data in the same cycle as the write command and are acknowledged in that cycle. The bus holds its request stable until it is acknowledged. It may present the next request in the cycle right after the acknowledge.

Top module: `sdram_row_sequencer`

## Requirements
- R1: While reset is held low, the command pins read deselect: sdCsN, sdRasN, sdCasN and sdWeN are all 1. reqAck and sdDqOe are 0. Reset also marks every bank as having no open row.
- R2: A request whose bank already has the requested row open puts its read or write command on the pins in the cycle after the request first appears. No activate is issued.
- R3: A request to a bank with no open row first issues an activate, {cs,ras,cas,we} = 0011. The activate appears in the cycle after the request, with the row on sdAddr and the bank on sdBa. Address bits are {row, bank, column}, with the column in the lowest COL_W bits.
- R4: After an activate, the read or write command follows exactly 2 cycles later when cfgRcd3 = 0, and exactly 3 cycles later when cfgRcd3 = 1.
- R5: A request to a bank that has a different row open first issues a precharge, {cs,ras,cas,we} = 0010, with sdAddr[10] = 0 and that bank on sdBa. The activate for the new row follows TRP cycles later (default 3).
- R6: The read command is {cs,ras,cas,we} = 0101. The column is zero-extended on sdAddr, so sdAddr[10] = 0, and sdBa carries the bank that was activated.
- R7: reqAck is raised for a read exactly 2 cycles after the read command when cfgCl3 = 0, and exactly 3 cycles after when cfgCl3 = 1. In that cycle reqRdata equals sdDqIn.
- R8: In the cycle after a read command, a burst-terminate command, {cs,ras,cas,we} = 0110, is issued only when both reqBurst and reqLoadMulti are 0. Otherwise that cycle carries a NOP.
- R9: The write command is {cs,ras,cas,we} = 0100. In the same cycle sdDqOe = 1, sdDqOut carries reqWdata and reqAck = 1. No burst-terminate follows a write. sdDqOe is 0 in every other cycle.
- R10: reqAck is high for exactly one cycle per request. A request presented in the cycle after the acknowledge is accepted, and its first command appears in the following cycle.
- R11: Outside reset, every cycle with no command to issue drives NOP, {cs,ras,cas,we} = 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgRcd3 | input | 1 | Row-to-column delay: 0 gives 2 cycles, 1 gives 3 |
| cfgCl3 | input | 1 | CAS latency: 0 gives 2 cycles, 1 gives 3 |
| reqValid | input | 1 | Request present, held until acknowledged |
| reqWrite | input | 1 | 1 selects write, 0 selects read |
| reqAddr | input | ROW_W+BANK_W+COL_W | Word address {row, bank, column} |
| reqWdata | input | DATA_W | Write data |
| reqBurst | input | 1 | More beats follow this one |
| reqLoadMulti | input | 1 | Load-multiple access, suppresses burst-terminate |
| reqAck | output | 1 | Transfer acknowledge, one cycle per request |
| reqRdata | output | DATA_W | Read data, valid while reqAck is high on a read |
| sdCsN | output | 1 | Chip-select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | ROW_W | Multiplexed row/column address |
| sdBa | output | BANK_W | Bank address |
| sdDqOut | output | DATA_W | Data driven toward the device |
| sdDqOe | output | 1 | Output enable for sdDqOut |
| sdDqIn | input | DATA_W | Data returned by the device |

## Verification
The bench targets the three paths through the row table: the first access to a bank, a hit, and a row conflict in a bank that is already open. A design that skipped the precharge, or that compared against the wrong bank's row, would show a missing or extra command in the cycle-by-cycle comparison. Each pairing of row-to-column delay and CAS latency is driven, so an off-by-one counter shows up as a command or acknowledge landing one cycle early or late. An 8-beat burst and a load-multiple read check that burst-terminate appears only after a final beat that is not a load-multiple access; a design that terminated every beat, or never terminated, would produce an unexpected or missing 0110 word. Back-to-back requests check that the block accepts a new request in the cycle after the acknowledge and does not issue the old request a second time.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_BST,
    CMD_PRE
  } sdCmd_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    sdCmd_e cmd;
    logic   markOpen;    // record the requested row as open in its bank
    logic   markClosed;  // forget the open row of the requested bank
  } ctlStrobe_t;

  // {ras, cas, we} levels for each command; chip-select is low for all of them
  function automatic logic [2:0] cmdPins(sdCmd_e c);
    case (c)
      CMD_ACT: return 3'b011;
      CMD_RD:  return 3'b101;
      CMD_WR:  return 3'b100;
      CMD_BST: return 3'b110;
      CMD_PRE: return 3'b010;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/sdram_seq_datapath.sv
module sdram_seq_datapath
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strobe,
  input  logic [ROW_W+BANK_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W-1:0]             dqIn,
  output logic                          rowHit,
  output logic                          bankOpen,
  output logic                          csN,
  output logic                          rasN,
  output logic                          casN,
  output logic                          weN,
  output logic [ROW_W-1:0]              sdAddr,
  output logic [BANK_W-1:0]             sdBa,
  output logic [DATA_W-1:0]             dqOut,
  output logic                          dqOe,
  output logic [DATA_W-1:0]             rdData
);

  localparam int NUM_BANKS = 1 << BANK_W;

  logic [COL_W-1:0]  reqCol;
  logic [BANK_W-1:0] reqBank;
  logic [ROW_W-1:0]  reqRow;
  logic [ROW_W-1:0]  colOnBus;

  assign reqCol   = reqAddr[COL_W-1:0];
  assign reqBank  = reqAddr[COL_W +: BANK_W];
  assign reqRow   = reqAddr[COL_W+BANK_W +: ROW_W];
  assign colOnBus = {{(ROW_W-COL_W){1'b0}}, reqCol};

  // Open-row table
  logic [NUM_BANKS-1:0] openValid;
  logic [ROW_W-1:0]     openRow [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openValid <= '0;
      for (int b = 0; b < NUM_BANKS; b++) openRow[b] <= '0;
    end else if (strobe.markClosed) begin
      openValid[reqBank] <= 1'b0;
    end else if (strobe.markOpen) begin
      openValid[reqBank] <= 1'b1;
      openRow[reqBank]   <= reqRow;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bankHit[b] = openValid[b] && (openRow[b] == reqRow);
  end

  assign rowHit   = bankHit[reqBank];
  assign bankOpen = openValid[reqBank];

  // Registered command, address and write data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      {csN, rasN, casN, weN} <= 4'b1111;
      sdAddr <= '0;
      sdBa   <= '0;
      dqOut  <= '0;
      dqOe   <= 1'b0;
    end else begin
      csN               <= 1'b0;
      {rasN, casN, weN} <= cmdPins(strobe.cmd);
      dqOe              <= (strobe.cmd == CMD_WR);
      case (strobe.cmd)
        CMD_ACT: begin
          sdAddr <= reqRow;
          sdBa   <= reqBank;
        end
        CMD_RD, CMD_WR: begin
          sdAddr <= colOnBus;
          sdBa   <= reqBank;
        end
        CMD_PRE: begin
          sdAddr <= '0;
          sdBa   <= reqBank;
        end
        default: ;
      endcase
      if (strobe.cmd == CMD_WR) dqOut <= reqWdata;
    end
  end

  assign rdData = dqIn;

  // An activate is always followed by a NOP (the delay is at least 2)
  assert_act_then_nop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && weN) |=> (!csN && rasN && casN && weN));

  // A precharged bank is marked closed in the table
  assert_pre_closes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && !weN) |-> !openValid[sdBa]);

endmodule

// File: rtl/sdram_seq_control.sv
module sdram_seq_control
  import sdram_seq_pkg::*;
#(
  parameter int TRP = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgRcd3,
  input  logic       cfgCl3,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqBurst,
  input  logic       reqLoadMulti,
  input  logic       rowHit,
  input  logic       bankOpen,
  output ctlStrobe_t strobe,
  output logic       reqAck
);

  localparam int CNT_W = ($clog2(TRP + 1) < 2) ? 2 : $clog2(TRP + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE_WAIT, S_ACT_WAIT, S_RD_WAIT, S_RD_DATA, S_WR
  } state_e;

  state_e           state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             bstPend, nextBst;
  logic             issue;
  logic [CNT_W-1:0] rcdLoad, clLoad, preLoad;

  assign rcdLoad = cfgRcd3 ? CNT_W'(2) : CNT_W'(1);
  assign clLoad  = cfgCl3  ? CNT_W'(2) : CNT_W'(1);
  assign preLoad = CNT_W'(TRP - 2);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    nextBst   = bstPend;
    issue     = 1'b0;
    strobe    = '{cmd: CMD_NOP, markOpen: 1'b0, markClosed: 1'b0};
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (rowHit) begin
            issue = 1'b1;
          end else if (bankOpen) begin
            strobe.cmd        = CMD_PRE;
            strobe.markClosed = 1'b1;
            nextState         = S_PRE_WAIT;
            nextCnt           = preLoad;
          end else begin
            strobe.cmd      = CMD_ACT;
            strobe.markOpen = 1'b1;
            nextState       = S_ACT_WAIT;
            nextCnt         = rcdLoad;
          end
        end
      end
      S_PRE_WAIT: begin
        if (cnt == '0) nextState = S_IDLE;
        else           nextCnt   = cnt - 1'b1;
      end
      S_ACT_WAIT: begin
        if (cnt == '0) issue   = 1'b1;
        else           nextCnt = cnt - 1'b1;
      end
      S_RD_WAIT: begin
        if (bstPend) begin
          strobe.cmd = CMD_BST;
          nextBst    = 1'b0;
        end
        if (cnt == '0) nextState = S_RD_DATA;
        else           nextCnt   = cnt - 1'b1;
      end
      S_RD_DATA, S_WR: nextState = S_IDLE;
      default:         nextState = S_IDLE;
    endcase
    if (issue) begin
      if (reqWrite) begin
        strobe.cmd = CMD_WR;
        nextState  = S_WR;
      end else begin
        strobe.cmd = CMD_RD;
        nextState  = S_RD_WAIT;
        nextCnt    = clLoad;
        nextBst    = !reqBurst && !reqLoadMulti;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bstPend <= 1'b0;
    end else begin
      state   <= nextState;
      cnt     <= nextCnt;
      bstPend <= nextBst;
    end
  end

  assign reqAck = (state == S_RD_DATA) || (state == S_WR);

  assert_single_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

endmodule

// File: rtl/sdram_row_sequencer.sv
module sdram_row_sequencer
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int DATA_W = 32,
  parameter int TRP    = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgRcd3,
  input  logic                          cfgCl3,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [ROW_W+BANK_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic                          reqBurst,
  input  logic                          reqLoadMulti,
  output logic                          reqAck,
  output logic [DATA_W-1:0]             reqRdata,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [ROW_W-1:0]              sdAddr,
  output logic [BANK_W-1:0]             sdBa,
  output logic [DATA_W-1:0]             sdDqOut,
  output logic                          sdDqOe,
  input  logic [DATA_W-1:0]             sdDqIn
);

  ctlStrobe_t strobe;
  logic       rowHit;
  logic       bankOpen;

  sdram_seq_control #(.TRP(TRP)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .cfgRcd3      (cfgRcd3),
    .cfgCl3       (cfgCl3),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqBurst     (reqBurst),
    .reqLoadMulti (reqLoadMulti),
    .rowHit       (rowHit),
    .bankOpen     (bankOpen),
    .strobe       (strobe),
    .reqAck       (reqAck)
  );

  sdram_seq_datapath #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .DATA_W(DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .dqIn     (sdDqIn),
    .rowHit   (rowHit),
    .bankOpen (bankOpen),
    .csN      (sdCsN),
    .rasN     (sdRasN),
    .casN     (sdCasN),
    .weN      (sdWeN),
    .sdAddr   (sdAddr),
    .sdBa     (sdBa),
    .dqOut    (sdDqOut),
    .dqOe     (sdDqOe),
    .rdData   (reqRdata)
  );

  logic [3:0] pinCmd;
  logic       pinAct, pinRd, pinWr, pinBst;
  assign pinCmd = {sdCsN, sdRasN, sdCasN, sdWeN};
  assign pinAct = (pinCmd == 4'b0011);
  assign pinRd  = (pinCmd == 4'b0101);
  assign pinWr  = (pinCmd == 4'b0100);
  assign pinBst = (pinCmd == 4'b0110);

  assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pinRd || pinWr) |-> !$past(pinAct));

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck && !reqWrite) |-> (cfgCl3 ? $past(pinRd, 3) : $past(pinRd, 2)));

  assert_bst_after_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    pinBst |-> $past(pinRd));

  assert_write_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    pinWr |-> (reqAck && sdDqOe));

endmodule

// File: tb/sdram_row_sequencer_tb.sv
module sdram_row_sequencer_tb;

  localparam int COL_W  = 8;
  localparam int ROW_W  = 12;
  localparam int BANK_W = 2;
  localparam int DATA_W = 32;
  localparam int TRP    = 3;
  localparam int AW     = ROW_W + BANK_W + COL_W;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_PRE = 4'b0010;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgRcd3 = 1'b0, cfgCl3 = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0]     reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqBurst = 1'b0, reqLoadMulti = 1'b0;
  logic              reqAck;
  logic [DATA_W-1:0] reqRdata;
  logic              sdCsN, sdRasN, sdCasN, sdWeN;
  logic [ROW_W-1:0]  sdAddr;
  logic [BANK_W-1:0] sdBa;
  logic [DATA_W-1:0] sdDqOut;
  logic              sdDqOe;
  logic [DATA_W-1:0] sdDqIn = 32'hDEAD_BEEF;

  sdram_row_sequencer u_dut (
    .clk(clk), .rstN(rstN), .cfgRcd3(cfgRcd3), .cfgCl3(cfgCl3),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBurst(reqBurst), .reqLoadMulti(reqLoadMulti),
    .reqAck(reqAck), .reqRdata(reqRdata),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr), .sdBa(sdBa), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe),
    .sdDqIn(sdDqIn)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail   = 0;
  bit cmpOn   = 1'b0;

  // Expected command stream, keyed by cycle
  logic [3:0]        expCmd [int];
  logic [ROW_W-1:0]  expAd  [int];
  logic [BANK_W-1:0] expBa  [int];
  logic [DATA_W-1:0] expWr  [int];

  // Bench view of open rows and memory contents
  bit                bOpen [4];
  int                bRow  [4];
  logic [DATA_W-1:0] refMem [int];

  // Behavioural device model
  int                mRow [4];
  logic [DATA_W-1:0] mMem [int];
  logic [DATA_W-1:0] rdQ  [int];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic string reqOf(logic [3:0] c);
    case (c)
      C_ACT:   return "R3";
      C_RD:    return "R6";
      C_WR:    return "R9";
      C_BST:   return "R8";
      C_PRE:   return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic void put(int t, logic [3:0] c, int ad, int ba);
    expCmd[t] = c;
    expAd[t]  = ROW_W'(ad);
    expBa[t]  = BANK_W'(ba);
  endfunction

  // Device model: observe commands, return read data CL cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        case ({sdCsN, sdRasN, sdCasN, sdWeN})
          C_ACT: mRow[sdBa] = int'(sdAddr);
          C_RD: begin
            int k;
            k = (int'(sdBa) << 20) | (mRow[sdBa] << 8) | int'(sdAddr[COL_W-1:0]);
            rdQ[cyc + (cfgCl3 ? 3 : 2)] = mMem.exists(k) ? mMem[k] : '0;
          end
          C_WR: begin
            int k;
            k = (int'(sdBa) << 20) | (mRow[sdBa] << 8) | int'(sdAddr[COL_W-1:0]);
            if (sdDqOe) mMem[k] = sdDqOut;
          end
          default: ;
        endcase
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      sdDqIn = rdQ.exists(cyc) ? rdQ[cyc] : 32'hDEAD_BEEF;
    end
  end

  // Cycle-by-cycle comparison of the command pins
  initial begin
    forever begin
      @(negedge clk);
      if (cmpOn) begin
        logic [3:0] e, p;
        e = expCmd.exists(cyc) ? expCmd[cyc] : C_NOP;
        p = {sdCsN, sdRasN, sdCasN, sdWeN};
        chk(p == e, reqOf(e), "command word", p, e);
        if (e == C_ACT || e == C_RD || e == C_WR) begin
          chk(sdAddr == expAd[cyc], reqOf(e), "sdAddr", sdAddr, expAd[cyc]);
          chk(sdBa == expBa[cyc], reqOf(e), "sdBa", sdBa, expBa[cyc]);
        end
        if (e == C_PRE) begin
          chk(sdAddr[10] == 1'b0, "R5", "precharge A10", sdAddr[10], 0);
          chk(sdBa == expBa[cyc], "R5", "precharge bank", sdBa, expBa[cyc]);
        end
        if (e == C_WR) begin
          chk(sdDqOe == 1'b1, "R9", "write output enable", sdDqOe, 1);
          chk(sdDqOut == expWr[cyc], "R9", "write data", sdDqOut, expWr[cyc]);
        end else begin
          chk(sdDqOe == 1'b0, "R9", "output enable off", sdDqOe, 0);
        end
      end
    end
  end

  task automatic doReq(input bit wr, input int bank, input int row, input int col,
                       input bit burst, input bit lm, input logic [DATA_W-1:0] wd);
    int r, t, endc, cl, rcd, waitN, key;
    logic [DATA_W-1:0] expD;
    reqValid     = 1'b1;
    reqWrite     = wr;
    reqAddr      = {ROW_W'(row), BANK_W'(bank), COL_W'(col)};
    reqWdata     = wd;
    reqBurst     = burst;
    reqLoadMulti = lm;
    r   = cyc;
    t   = r + 1;
    cl  = cfgCl3 ? 3 : 2;
    rcd = cfgRcd3 ? 3 : 2;
    key = (bank << 20) | (row << 8) | col;
    if (!(bOpen[bank] && bRow[bank] == row)) begin
      if (bOpen[bank]) begin
        put(t, C_PRE, 0, bank);
        t += TRP;
      end
      put(t, C_ACT, row, bank);
      bOpen[bank] = 1'b1;
      bRow[bank]  = row;
      t += rcd;
    end
    put(t, wr ? C_WR : C_RD, col, bank);
    expD = '0;
    if (wr) begin
      endc        = t;
      expWr[t]    = wd;
      refMem[key] = wd;
    end else begin
      endc = t + cl;
      expD = refMem.exists(key) ? refMem[key] : '0;
      if (!burst && !lm) put(t + 1, C_BST, 0, bank);
    end
    waitN = 0;
    @(negedge clk);
    while (!reqAck && waitN < 60) begin
      waitN++;
      @(negedge clk);
    end
    chk(reqAck, "R10", "acknowledge seen", reqAck, 1);
    chk(cyc == endc, wr ? "R9" : "R7", "acknowledge cycle", cyc, endc);
    if (!wr) chk(reqRdata == expD, "R7", "read data", reqRdata, expD);
    @(posedge clk); #1;
    chk(!reqAck, "R10", "acknowledge lasts one cycle", reqAck, 0);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b1111, "R1", "pins in reset",
        {sdCsN, sdRasN, sdCasN, sdWeN}, 4'hF);
    chk(!reqAck, "R1", "ack in reset", reqAck, 0);
    chk(!sdDqOe, "R1", "output enable in reset", sdDqOe, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    idle(2);
    cmpOn = 1'b1;
    idle(3);                                    // R11 idle NOPs

    // CL 2, RCD 2
    doReq(1, 0, 5, 3, 0, 0, 32'hA5A5_0001);     // R3 first access activates
    doReq(1, 0, 5, 4, 0, 0, 32'hA5A5_0002);     // R2 hit
    doReq(0, 0, 5, 3, 0, 0, '0);                // R2 R6 R8 R7
    for (int i = 0; i < 8; i++) doReq(1, 1, 7, i, 0, 0, 32'h1000_0000 + i);
    for (int i = 0; i < 8; i++) doReq(0, 1, 7, i, (i < 7), 0, '0); // R8 burst
    doReq(0, 1, 7, 2, 0, 1, '0);                // R8 load-multiple
    doReq(0, 0, 9, 1, 0, 0, '0);                // R5 conflict
    doReq(0, 0, 5, 4, 0, 0, '0);                // R5 back to first row
    idle(2);

    // CL 3, RCD 3
    cfgRcd3 = 1'b1; cfgCl3 = 1'b1;
    idle(1);
    doReq(1, 2, 100, 9, 0, 0, 32'hCAFE_0009);   // R4
    doReq(0, 2, 100, 9, 0, 0, '0);              // R7
    doReq(0, 3, 1, 0, 1, 0, '0);
    doReq(0, 3, 1, 1, 0, 0, '0);
    doReq(1, 2, 200, 9, 0, 0, 32'hCAFE_0200);   // R5
    doReq(0, 2, 200, 9, 0, 1, '0);
    doReq(0, 2, 100, 9, 0, 0, '0);

    // Mixed settings
    cfgRcd3 = 1'b1; cfgCl3 = 1'b0;
    idle(1);
    doReq(0, 1, 30, 5, 0, 0, '0);
    cfgRcd3 = 1'b0; cfgCl3 = 1'b1;
    idle(1);
    doReq(0, 3, 40, 6, 0, 0, '0);
    doReq(0, 0, 5, 3, 0, 0, '0);
    idle(6);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule